// File: doc/BRIEF.md
# LCG Table-Fill Engine

This peripheral fills one bank of a data RAM with a table of pseudo-random bytes. Software starts it by writing the control register with the start bit set. From the next cycle on, the engine issues one RAM write per clock, 255 in all. Each write puts one output of an 8-bit linear congruential generator at the address given by its position in the sequence.

The generator uses the recurrence R(n+1) = (0x11 * R(n) + 0x9D) mod 256 and restarts from 0xD7 on every run. The ninth address bit comes from the bank select input. That input is captured when the run starts. When the last byte is written, a done flag appears in the status register. Any later write to the control register clears it. The RAM and the processor lie outside the block.

Top module: `lcg_fill_engine`

## Requirements
- R1: After reset, mem_we is low and status_rd is 0x00.
- R2: The n-th written byte (n counted from 0) is R(n), where R(0) = 0xD7 and R(n+1) = (0x11 * R(n) + 0x9D) mod 256.
- R3: A run issues exactly 255 writes on consecutive cycles, with mem_addr[7:0] rising by one each cycle from 0x00 to 0xFE.
- R4: A control write with ctrl_wdata bit 0 = 1 starts a run. The first write (address 0x00, data 0xD7) appears in the cycle after the clock edge that takes the control write.
- R5: In the cycle after the final write, mem_we is low and status_rd bit 0 (done) is 1. All other status bits always read 0.
- R6: Every control write clears done. A control write with bit 0 = 0 starts nothing and issues no RAM write.
- R7: mem_addr[8] equals the value of bank_sel at the start edge and holds that value for the whole run, even if bank_sel changes.
- R8: A start write during a run restarts the sequence from index 0x00 and value 0xD7, and the new run issues a full 255 writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_wr | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 8 | Control write data; bit 0 is the start bit |
| bank_sel | input | 1 | Current RAM bank, captured at start |
| status_rd | output | 8 | Status register; bit 0 is done |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | 9 | RAM write address {bank, index} |
| mem_wdata | output | 8 | RAM write data, the generator output |

## Verification
Each run is checked against a reference sequence built with a true multiply rather than shift-and-add. The full 255-write run is done in both banks. This separates errors in the constants or the multiply from errors in index counting and bank routing. A bank change in mid-run shows whether the bank is latched at start or read live. A restart after 20 writes shows whether both the index and the value return to their start points. A control write with the start bit clear must clear done and cause no writes, which separates the clear path from the start path.

// File: rtl/lcg_fill_pkg.sv
package lcg_fill_pkg;

    localparam int unsigned DEF_DATA_W   = 8;
    localparam int unsigned DEF_REG_W    = 8;
    localparam int unsigned DEF_SHIFT    = 4;     // multiplier = 2**SHIFT + 1
    localparam int unsigned DEF_INCR     = 8'h9D;
    localparam int unsigned DEF_SEED     = 8'hD7;
    localparam int unsigned DEF_COUNT    = 255;

    localparam int unsigned START_BIT    = 0;
    localparam int unsigned DONE_BIT     = 0;

endpackage

// File: rtl/lcg_step.sv
module lcg_step #(
    parameter int unsigned W     = 8,
    parameter int unsigned SHIFT = 4,
    parameter int unsigned INCR  = 8'h9D
) (
    input  logic [W-1:0] cur_val,
    output logic [W-1:0] nxt_val
);
    localparam logic [W-1:0] INCR_W = W'(INCR);

    logic [W-1:0] scaled;

    generate
        if (SHIFT >= W) begin : g_shift_out
            // shifted copy falls off the top: multiplier reduces to 1
            assign scaled = cur_val;
        end else if (SHIFT == 0) begin : g_double
            assign scaled = cur_val + cur_val;
        end else begin : g_shift_add
            assign scaled = (cur_val << SHIFT) + cur_val;
        end
    endgenerate

    assign nxt_val = scaled + INCR_W;

endmodule

// File: rtl/fill_ctrl_regs.sv
module fill_ctrl_regs #(
    parameter int unsigned REG_W = 8
) (
    input  logic             ctrl_wr,
    input  logic [REG_W-1:0] ctrl_wdata,
    input  logic             done,
    output logic             start_req,
    output logic             clear_req,
    output logic [REG_W-1:0] status_rd
);
    import lcg_fill_pkg::*;

    always_comb begin
        start_req = ctrl_wr && ctrl_wdata[START_BIT];
        clear_req = ctrl_wr;
        status_rd = '0;
        status_rd[DONE_BIT] = done;
    end

endmodule

// File: rtl/fill_sequencer.sv
module fill_sequencer #(
    parameter int unsigned W     = 8,
    parameter int unsigned COUNT = 255,
    parameter int unsigned SEED  = 8'hD7,
    parameter int unsigned IDX_W = (COUNT > 1) ? $clog2(COUNT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             clear_req,
    input  logic             bank_sel,
    input  logic [W-1:0]     gen_next,
    output logic             running,
    output logic             done,
    output logic             bank,
    output logic [IDX_W-1:0] idx,
    output logic [W-1:0]     gen_val
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(COUNT - 1);
    localparam logic [W-1:0]     SEED_W   = W'(SEED);

    typedef struct packed {
        logic             running;
        logic             done;
        logic             bank;
        logic [IDX_W-1:0] idx;
        logic [W-1:0]     val;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.running) begin
            st_d.idx = st_q.idx + IDX_W'(1);
            st_d.val = gen_next;
            if (st_q.idx == LAST_IDX) begin
                st_d.running = 1'b0;
                st_d.done    = 1'b1;
            end
        end
        if (clear_req) begin
            st_d.done = 1'b0;
        end
        if (start_req) begin
            st_d.running = 1'b1;
            st_d.done    = 1'b0;
            st_d.bank    = bank_sel;
            st_d.idx     = '0;
            st_d.val     = SEED_W;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{running: 1'b0, done: 1'b0, bank: 1'b0, idx: '0, val: SEED_W};
        end else begin
            st_q <= st_d;
        end
    end

    assign running = st_q.running;
    assign done    = st_q.done;
    assign bank    = st_q.bank;
    assign idx     = st_q.idx;
    assign gen_val = st_q.val;

endmodule

// File: rtl/lcg_fill_engine.sv
module lcg_fill_engine #(
    parameter int unsigned W      = lcg_fill_pkg::DEF_DATA_W,
    parameter int unsigned REG_W  = lcg_fill_pkg::DEF_REG_W,
    parameter int unsigned SHIFT  = lcg_fill_pkg::DEF_SHIFT,
    parameter int unsigned INCR   = lcg_fill_pkg::DEF_INCR,
    parameter int unsigned SEED   = lcg_fill_pkg::DEF_SEED,
    parameter int unsigned COUNT  = lcg_fill_pkg::DEF_COUNT,
    parameter int unsigned IDX_W  = (COUNT > 1) ? $clog2(COUNT) : 1,
    parameter int unsigned ADDR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [REG_W-1:0]  ctrl_wdata,
    input  logic              bank_sel,
    output logic [REG_W-1:0]  status_rd,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [W-1:0]      mem_wdata
);
    logic             start_req;
    logic             clear_req;
    logic             running;
    logic             done;
    logic             bank;
    logic [IDX_W-1:0] idx;
    logic [W-1:0]     gen_val;
    logic [W-1:0]     gen_next;

    fill_ctrl_regs #(.REG_W(REG_W)) i_regs (
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .done       (done),
        .start_req  (start_req),
        .clear_req  (clear_req),
        .status_rd  (status_rd)
    );

    lcg_step #(.W(W), .SHIFT(SHIFT), .INCR(INCR)) i_step (
        .cur_val (gen_val),
        .nxt_val (gen_next)
    );

    fill_sequencer #(.W(W), .COUNT(COUNT), .SEED(SEED), .IDX_W(IDX_W)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .clear_req (clear_req),
        .bank_sel  (bank_sel),
        .gen_next  (gen_next),
        .running   (running),
        .done      (done),
        .bank      (bank),
        .idx       (idx),
        .gen_val   (gen_val)
    );

    assign mem_we    = running;
    assign mem_addr  = {bank, idx};
    assign mem_wdata = gen_val;

endmodule

// File: rtl/lcg_fill_checker.sv
module lcg_fill_checker #(
    parameter int unsigned W      = 8,
    parameter int unsigned REG_W  = 8,
    parameter int unsigned SHIFT  = 4,
    parameter int unsigned INCR   = 8'h9D,
    parameter int unsigned SEED   = 8'hD7,
    parameter int unsigned COUNT  = 255,
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctrl_wr,
    input logic [REG_W-1:0]  ctrl_wdata,
    input logic              bank_sel,
    input logic [REG_W-1:0]  status_rd,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [W-1:0]      mem_wdata
);
    localparam logic [W-1:0]     MULT_W = W'((64'd1 << SHIFT) + 64'd1);
    localparam logic [W-1:0]     INCR_W = W'(INCR);
    localparam logic [W-1:0]     SEED_W = W'(SEED);
    localparam logic [IDX_W-1:0] LAST   = IDX_W'(COUNT - 1);

    logic start;
    assign start = ctrl_wr && ctrl_wdata[0];

    assert_reset_R1: assert property (@(posedge clk) $rose(rst_n) |-> !mem_we && status_rd == '0);

    assert_recur_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && !start |=> !mem_we || mem_wdata == W'($past(mem_wdata) * MULT_W + INCR_W));

    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && !start && mem_addr[IDX_W-1:0] != LAST
        |=> mem_we && mem_addr[IDX_W-1:0] == $past(mem_addr[IDX_W-1:0]) + IDX_W'(1));

    assert_start_seed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> mem_we && mem_wdata == SEED_W && mem_addr[IDX_W-1:0] == '0);

    assert_finish_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && mem_addr[IDX_W-1:0] == LAST && !ctrl_wr |=> !mem_we && status_rd[0]);

    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && status_rd[0]));

    assert_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        status_rd[REG_W-1:1] == '0);

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> !status_rd[0]);

    assert_idle_stays_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we && !start |=> !mem_we);

    assert_bank_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && !start |=> !mem_we || mem_addr[ADDR_W-1] == $past(mem_addr[ADDR_W-1]));

    assert_bank_pick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> mem_addr[ADDR_W-1] == $past(bank_sel));

endmodule

bind lcg_fill_engine lcg_fill_checker #(
    .W(W), .REG_W(REG_W), .SHIFT(SHIFT), .INCR(INCR), .SEED(SEED),
    .COUNT(COUNT), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
) i_lcg_fill_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (ctrl_wdata),
    .bank_sel   (bank_sel),
    .status_rd  (status_rd),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata)
);

// File: tb/test_lcg_fill_engine.sv
`timescale 1ns/100ps
module test_lcg_fill_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [7:0] ctrl_wdata = 8'h00;
    logic       bank_sel = 1'b0;
    logic [7:0] status_rd;
    logic       mem_we;
    logic [8:0] mem_addr;
    logic [7:0] mem_wdata;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    lcg_fill_engine i_lcg_fill_engine (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .bank_sel(bank_sel), .status_rd(status_rd), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_next(input logic [7:0] r);
        int unsigned p;
        p = 32'(r) * 32'd17 + 32'd157;
        return p[7:0];
    endfunction

    task automatic reg_write(input logic [7:0] d);
        @(posedge clk); #1;
        ctrl_wr = 1'b1; ctrl_wdata = d;
        @(posedge clk); #1;
        ctrl_wr = 1'b0; ctrl_wdata = 8'h00;
    endtask

    // check writes idx first..254 starting from value v; optional bank flip
    task automatic follow_run(input logic bank, input int first, input logic [7:0] v0,
                              input bit flip_bank);
        logic [7:0] v = v0;
        for (int i = first; i < 255; i++) begin
            @(negedge clk);
            chk(mem_we === 1'b1, "R3 write enable", int'(mem_we), 1);
            chk(mem_addr[7:0] === 8'(i), "R3 index", int'(mem_addr[7:0]), i);
            chk(mem_addr[8] === bank, "R7 bank bit", int'(mem_addr[8]), int'(bank));
            chk(mem_wdata === v, "R2 value", int'(mem_wdata), int'(v));
            chk(status_rd[0] === 1'b0, "R5 done low in run", int'(status_rd), 0);
            if (flip_bank && i == 10) bank_sel = ~bank_sel;
            v = ref_next(v);
        end
        @(negedge clk);
        chk(mem_we === 1'b0, "R5 we low after run", int'(mem_we), 0);
        chk(status_rd === 8'h01, "R5 done set", int'(status_rd), 1);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(mem_we === 1'b0, "R1 we after reset", int'(mem_we), 0);
        chk(status_rd === 8'h00, "R1 status after reset", int'(status_rd), 0);
    endtask

    task automatic t_run_bank0;
        bank_sel = 1'b0;
        reg_write(8'h01);
        follow_run(1'b0, 0, 8'hD7, 1'b0);   // R4 first write at 0x00 with 0xD7
    endtask

    task automatic t_run_bank1_latched;
        bank_sel = 1'b1;
        reg_write(8'h01);
        follow_run(1'b1, 0, 8'hD7, 1'b1);
        bank_sel = 1'b0;
    endtask

    task automatic t_clear_no_start;
        reg_write(8'h00);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(status_rd === 8'h00, "R6 done cleared", int'(status_rd), 0);
            chk(mem_we === 1'b0, "R6 no write on bit0=0", int'(mem_we), 0);
        end
    endtask

    task automatic t_restart;
        logic [7:0] v = 8'hD7;
        bank_sel = 1'b0;
        reg_write(8'h01);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(mem_wdata === v && mem_addr[7:0] === 8'(i), "R8 pre-restart",
                int'(mem_wdata), int'(v));
            v = ref_next(v);
        end
        reg_write(8'h01);
        follow_run(1'b0, 0, 8'hD7, 1'b0);   // R8 full run after restart
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_run_bank0();
        t_clear_no_start();
        t_run_bank1_latched();
        t_restart();
        t_clear_no_start();
        repeat (2) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule